// File: doc/BRIEF.md
# Path Trace Identifier Monitor

This block watches the path trace byte that arrives once per frame, marked by a one-cycle strobe. It assembles consecutive bytes into a trace message and checks each finished message against a reference. A mode input selects the reference and the way message boundaries are found. Three modes count a fixed, programmable number of bytes from the last restart. Two modes find their own alignment in the byte stream: one locks on a start byte with its top bit set, and one locks on a carriage-return/line-feed terminator.

The block drives three outputs. The first is a mismatch alarm that is updated at each finished message. The second is a one-cycle pulse that fires when a new trace is taken into the accepted store. The third is an out-of-alignment flag for the self-aligning modes. The accepted store can be read byte by byte through an asynchronous read port. A synchronous write port loads the expected message that the programmed mode compares against. Changing the mode or the length restarts message assembly.

Top module: `trace_id_monitor`

## Requirements
- R1: After reset, `mismatch` and `new_trace` are 0 and every byte of the accepted store reads 0. `out_of_align` is 0 in a counting mode and 1 in a self-aligning mode.
- R2: In counting modes the message length is `msg_len`, with a valid range of 1 to 64. Any other value is treated as 64. Only the first length bytes of the message take part in a comparison, and no message finishes before its last byte arrives.
- R3: In cyclic mode (code 0), each finished message is compared with the previous finished message. The cycle after the final byte's strobe, `mismatch` goes to 1 if the two differ and to 0 if they are equal. Between finished messages `mismatch` holds its value.
- R4: In programmed mode (code 1), `mismatch` compares the message with the expected store. A write on `exp_we` loads byte `exp_addr` with `exp_wdata`, and the new value applies to every message that finishes after the write cycle.
- R5: Mode code 3 is the 16-byte self-aligning mode. The block is out of alignment until a byte with bit 7 set arrives, and that byte becomes position 0. If a byte with bit 7 clear arrives where position 0 is due, alignment is lost. If a byte with bit 7 set arrives in the middle of a message, the partial message is dropped and a new message starts at that byte.
- R6: Mode code 2 is the 64-byte self-aligning mode. Alignment is gained after the byte 0x0D is followed by 0x0A. An aligned message finishes only if its last two bytes are 0x0D and 0x0A. Otherwise alignment is lost and the message is dropped, with no change to any output other than `out_of_align`.
- R7: In both self-aligning modes, a finished message is compared with the previous finished message. Bytes that arrive while the block is out of alignment change neither `mismatch` nor `new_trace`.
- R8: In persistence mode (code 4), a message is accepted once it has finished identical to the previous message `persist_n` times in a row, where a `persist_n` of 0 counts as 1. `mismatch` is 1 when the finished message differs from the accepted one and is not accepted at that finish.
- R9: In every mode except persistence, each finished message becomes the accepted message. `rd_data` always shows byte `rd_addr` of the accepted store.
- R10: `new_trace` is a one-cycle pulse, issued the cycle after a finish that changes the accepted content within the message length.
- R11: A change of `mode_sel` or `msg_len` drops any partial message and resets the persistence count. It restarts at position 0, out of alignment if the new mode is self-aligning. A strobe in the cycle of the change is ignored.
- R12: Mode codes 5 to 7 behave like cyclic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_strb | input | 1 | Trace byte valid strobe |
| trc_byte | input | 8 | Received trace byte |
| mode_sel | input | 3 | Comparison mode code |
| msg_len | input | 7 | Message length for counting modes |
| persist_n | input | 4 | Consecutive repeats needed in persistence mode |
| exp_we | input | 1 | Expected store write enable |
| exp_addr | input | 6 | Expected store byte address |
| exp_wdata | input | 8 | Expected store write data |
| rd_addr | input | 6 | Accepted store read address |
| rd_data | output | 8 | Accepted store byte at `rd_addr` |
| mismatch | output | 1 | Trace mismatch alarm |
| new_trace | output | 1 | New trace accepted pulse |
| out_of_align | output | 1 | Self-aligning mode has no alignment |

## Verification
The bench sweeps the length from 1 to 8 in cyclic mode and changes only the last byte of each message. A design with an off-by-one in the terminal count would finish too early or too late, and would flag or miss that one-byte change. The bench also sets the out-of-range length 0, checks that nothing finishes after 63 bytes, and writes a mismatching expected byte beyond the length, which must not raise the alarm.

In the 16-byte mode the bench injects a stray start byte mid-message and a non-start byte at position 0. In the 64-byte mode it sends a lone carriage return and a message with a bad terminator. A design that failed to realign would finish the wrong bytes, and one that failed to drop the bad message would disturb the alarm. In persistence mode the bench breaks the run of repeats, and a miscounting design would pulse `new_trace` one message early or late. A mid-message length change exposes a design that keeps the stale position.

// File: rtl/trc_pkg.sv
package trc_pkg;

   localparam logic [2:0] M_CYCLIC  = 3'd0;
   localparam logic [2:0] M_PROG    = 3'd1;
   localparam logic [2:0] M_SONET   = 3'd2;
   localparam logic [2:0] M_SDH     = 3'd3;
   localparam logic [2:0] M_PERSIST = 3'd4;

   localparam logic [7:0] CHR_CR = 8'h0D;
   localparam logic [7:0] CHR_LF = 8'h0A;

   function automatic logic is_framing(input logic [2:0] m);
      return (m == M_SONET) || (m == M_SDH);
   endfunction

endpackage

// File: rtl/trc_align.sv
module trc_align
   import trc_pkg::*;
#(
   parameter int MAX_LEN   = 64,
   parameter int SDH_LEN   = 16,
   parameter int SONET_LEN = 64,
   parameter int LW        = $clog2(MAX_LEN + 1),
   parameter int PW        = $clog2(MAX_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          strb,
   input  logic [7:0]    data,
   input  logic [2:0]    mode,
   input  logic [LW-1:0] len_cfg,
   output logic          store,
   output logic [PW-1:0] wpos,
   output logic          done,
   output logic          oof,
   output logic [LW-1:0] eff_len
);

   initial begin
      assert (SONET_LEN <= MAX_LEN && SDH_LEN <= MAX_LEN)
         else $error("framing lengths exceed store depth");
      assert (SDH_LEN >= 2 && SONET_LEN >= 2)
         else $error("framing lengths too short");
   end

   logic          aligned_q, aligned_d;
   logic [PW-1:0] pos_q, pos_d;
   logic          cr_q, cr_d;
   logic          at_end;
   logic          framing;

   assign framing = is_framing(mode);
   assign oof     = framing && !aligned_q;

   always_comb begin
      if (mode == M_SDH)
         eff_len = LW'(SDH_LEN);
      else if (mode == M_SONET)
         eff_len = LW'(SONET_LEN);
      else if (len_cfg == '0 || len_cfg > LW'(MAX_LEN))
         eff_len = LW'(MAX_LEN);
      else
         eff_len = len_cfg;
   end

   assign at_end = (LW'(pos_q) == eff_len - LW'(1));

   always_comb begin
      store     = 1'b0;
      done      = 1'b0;
      wpos      = pos_q;
      pos_d     = pos_q;
      aligned_d = aligned_q;
      cr_d      = cr_q;
      if (restart) begin
         pos_d     = '0;
         aligned_d = !framing;
         cr_d      = 1'b0;
      end else if (strb) begin
         cr_d = (data == CHR_CR);
         case (mode)
            M_SDH: begin
               if (data[7]) begin
                  store     = 1'b1;
                  wpos      = '0;
                  pos_d     = PW'(1);
                  aligned_d = 1'b1;
               end else if (aligned_q) begin
                  if (pos_q == '0) begin
                     aligned_d = 1'b0;
                  end else begin
                     store = 1'b1;
                     if (at_end) begin
                        done  = 1'b1;
                        pos_d = '0;
                     end else begin
                        pos_d = pos_q + PW'(1);
                     end
                  end
               end
            end
            M_SONET: begin
               if (!aligned_q) begin
                  if (cr_q && data == CHR_LF) begin
                     aligned_d = 1'b1;
                     pos_d     = '0;
                  end
               end else begin
                  store = 1'b1;
                  if (at_end) begin
                     pos_d = '0;
                     if (cr_q && data == CHR_LF)
                        done = 1'b1;
                     else
                        aligned_d = 1'b0;
                  end else begin
                     pos_d = pos_q + PW'(1);
                  end
               end
            end
            default: begin
               store = 1'b1;
               if (at_end) begin
                  done  = 1'b1;
                  pos_d = '0;
               end else begin
                  pos_d = pos_q + PW'(1);
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aligned_q <= 1'b0;
         pos_q     <= '0;
         cr_q      <= 1'b0;
      end else begin
         aligned_q <= aligned_d;
         pos_q     <= pos_d;
         cr_q      <= cr_d;
      end
   end

   // R2: an aligned position never reaches the message length
   p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned_q && !restart) |-> (LW'(pos_q) < eff_len));

   // R5: the 16-byte mode only locks on a start byte
   p_sdh_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SDH && !$past(restart) && $fell(oof)) |-> $past(strb && data[7]));

   // R6: the 64-byte mode only locks on a line feed
   p_sonet_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SONET && !$past(restart) && $fell(oof)) |-> $past(strb && data == CHR_LF));

endmodule

// File: rtl/trc_cmp.sv
module trc_cmp #(
   parameter int MAX_LEN = 64,
   parameter int LW      = $clog2(MAX_LEN + 1)
) (
   input  logic [MAX_LEN*8-1:0] a,
   input  logic [MAX_LEN*8-1:0] b,
   input  logic [LW-1:0]        len,
   output logic                 diff
);

   logic [MAX_LEN-1:0] ne;

   for (genvar g = 0; g < MAX_LEN; g++) begin : g_byte
      assign ne[g] = (a[g*8 +: 8] != b[g*8 +: 8]) && (LW'(g) < len);
   end

   assign diff = |ne;

endmodule

// File: rtl/trace_id_monitor.sv
module trace_id_monitor
   import trc_pkg::*;
#(
   parameter int MAX_LEN   = 64,
   parameter int SDH_LEN   = 16,
   parameter int SONET_LEN = 64,
   parameter int CNT_W     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         trc_strb,
   input  logic [7:0]                   trc_byte,
   input  logic [2:0]                   mode_sel,
   input  logic [$clog2(MAX_LEN+1)-1:0] msg_len,
   input  logic [CNT_W-1:0]             persist_n,
   input  logic                         exp_we,
   input  logic [$clog2(MAX_LEN)-1:0]   exp_addr,
   input  logic [7:0]                   exp_wdata,
   input  logic [$clog2(MAX_LEN)-1:0]   rd_addr,
   output logic [7:0]                   rd_data,
   output logic                         mismatch,
   output logic                         new_trace,
   output logic                         out_of_align
);

   localparam int LW = $clog2(MAX_LEN + 1);
   localparam int PW = $clog2(MAX_LEN);
   localparam int MW = MAX_LEN * 8;
   localparam int CW = 3 + LW;

   initial begin
      assert (MAX_LEN >= 2 && (1 << PW) == MAX_LEN)
         else $error("MAX_LEN must be a power of two of at least 2");
      assert (CNT_W >= 1 && CNT_W <= 8)
         else $error("CNT_W out of range");
   end

   logic [CW-1:0]    cfg_q;
   logic             restart;
   logic             store, done;
   logic [PW-1:0]    wpos;
   logic [LW-1:0]    eff_len;
   logic [MW-1:0]    rx_q, last_q, acc_q, exp_q, msg_w;
   logic             diff_last, diff_exp, diff_acc;
   logic [CNT_W-1:0] run_q, run_nxt, n_eff;
   logic             accept, persist;
   logic             mm_q, new_q;

   assign restart = ({mode_sel, msg_len} != cfg_q);
   assign persist = (mode_sel == M_PERSIST);

   trc_align #(
      .MAX_LEN(MAX_LEN), .SDH_LEN(SDH_LEN), .SONET_LEN(SONET_LEN), .LW(LW), .PW(PW)
   ) u_align (
      .clk(clk), .rst_n(rst_n), .restart(restart), .strb(trc_strb), .data(trc_byte),
      .mode(mode_sel), .len_cfg(msg_len), .store(store), .wpos(wpos), .done(done),
      .oof(out_of_align), .eff_len(eff_len)
   );

   always_comb begin
      msg_w = rx_q;
      msg_w[{wpos, 3'b000} +: 8] = trc_byte;
   end

   trc_cmp #(.MAX_LEN(MAX_LEN), .LW(LW)) u_cmp_last (
      .a(msg_w), .b(last_q), .len(eff_len), .diff(diff_last));
   trc_cmp #(.MAX_LEN(MAX_LEN), .LW(LW)) u_cmp_exp (
      .a(msg_w), .b(exp_q), .len(eff_len), .diff(diff_exp));
   trc_cmp #(.MAX_LEN(MAX_LEN), .LW(LW)) u_cmp_acc (
      .a(msg_w), .b(acc_q), .len(eff_len), .diff(diff_acc));

   assign n_eff   = (persist_n == '0) ? CNT_W'(1) : persist_n;
   assign run_nxt = diff_last ? CNT_W'(1) : ((&run_q) ? run_q : run_q + CNT_W'(1));
   assign accept  = (run_nxt >= n_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         rx_q   <= '0;
         last_q <= '0;
         acc_q  <= '0;
         exp_q  <= '0;
         run_q  <= '0;
         mm_q   <= 1'b0;
         new_q  <= 1'b0;
      end else begin
         cfg_q <= {mode_sel, msg_len};
         new_q <= 1'b0;
         if (store)
            rx_q[{wpos, 3'b000} +: 8] <= trc_byte;
         if (exp_we)
            exp_q[{exp_addr, 3'b000} +: 8] <= exp_wdata;
         if (restart) begin
            run_q <= '0;
         end else if (done) begin
            last_q <= msg_w;
            if (persist) begin
               run_q <= run_nxt;
               mm_q  <= diff_acc && !accept;
               if (accept && diff_acc) begin
                  acc_q <= msg_w;
                  new_q <= 1'b1;
               end
            end else begin
               acc_q <= msg_w;
               new_q <= diff_acc;
               mm_q  <= (mode_sel == M_PROG) ? diff_exp : diff_last;
            end
         end
      end
   end

   assign mismatch  = mm_q;
   assign new_trace = new_q;
   assign rd_data   = acc_q[{rd_addr, 3'b000} +: 8];

   // R3: the alarm moves only after a finished message
   p_mm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(done) |-> $stable(mismatch));

   // R10: a new-trace pulse follows a finished message
   p_new_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      new_trace |-> $past(done));

   // R9: the accepted store changes only after a finished message
   p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(done) |-> $stable(acc_q));

   // R11: a restart into a self-aligning mode leaves it unaligned
   p_restart_unlock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(restart) && $stable(mode_sel) && is_framing(mode_sel)) |-> out_of_align);

endmodule

// File: tb/tb_trace_id_monitor.sv
module tb_trace_id_monitor;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trc_strb = 1'b0;
   logic [7:0] trc_byte = '0;
   logic [2:0] mode_sel = 3'd0;
   logic [6:0] msg_len = 7'd4;
   logic [3:0] persist_n = 4'd1;
   logic       exp_we = 1'b0;
   logic [5:0] exp_addr = '0;
   logic [7:0] exp_wdata = '0;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       mismatch, new_trace, out_of_align;

   trace_id_monitor dut (
      .clk(clk), .rst_n(rst_n), .trc_strb(trc_strb), .trc_byte(trc_byte),
      .mode_sel(mode_sel), .msg_len(msg_len), .persist_n(persist_n),
      .exp_we(exp_we), .exp_addr(exp_addr), .exp_wdata(exp_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data), .mismatch(mismatch),
      .new_trace(new_trace), .out_of_align(out_of_align)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [7:0] msg    [64];
   logic [7:0] m_last [64];
   logic [7:0] m_acc  [64];
   logic [7:0] m_exp  [64];
   int  run = 0;
   int  cur_mode = 0;
   int  cur_n = 1;
   bit  e_mm = 0;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      trc_strb = 1'b1;
      trc_byte = b;
      @(negedge clk);
      trc_strb = 1'b0;
   endtask

   task automatic set_cfg(input int m, input int l);
      @(negedge clk);
      mode_sel = 3'(m);
      msg_len  = 7'(l);
      cur_mode = m;
      run      = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic write_exp(input int a, input logic [7:0] d);
      @(negedge clk);
      exp_we = 1'b1; exp_addr = 6'(a); exp_wdata = d;
      @(negedge clk);
      exp_we = 1'b0;
      m_exp[a] = d;
   endtask

   task automatic model_check(input int len, input string tag);
      bit dl = 0, de = 0, da = 0, e_new, ok;
      for (int i = 0; i < len; i++) begin
         if (msg[i] != m_last[i]) dl = 1;
         if (msg[i] != m_exp[i])  de = 1;
         if (msg[i] != m_acc[i])  da = 1;
      end
      if (cur_mode == 4) begin
         run   = dl ? 1 : ((run >= 15) ? 15 : run + 1);
         ok    = run >= ((cur_n == 0) ? 1 : cur_n);
         e_new = ok && da;
         e_mm  = da && !ok;
      end else begin
         ok    = 1;
         e_new = da;
         e_mm  = (cur_mode == 1) ? de : dl;
      end
      for (int i = 0; i < len; i++) begin
         m_last[i] = msg[i];
         if (ok) m_acc[i] = msg[i];
      end
      chk({tag, " mismatch"}, {7'd0, mismatch}, {7'd0, e_mm});
      chk({tag, " new_trace"}, {7'd0, new_trace}, {7'd0, e_new});
   endtask

   task automatic send_msg(input int len, input string tag);
      for (int i = 0; i < len; i++) send_byte(msg[i]);
      model_check(len, tag);
   endtask

   task automatic chk_read(input int len);
      for (int i = 0; i < len; i++) begin
         rd_addr = 6'(i);
         #1;
         chk("R9 read port", rd_data, m_acc[i]);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 100000);
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         m_last[i] = '0; m_acc[i] = '0; m_exp[i] = '0; msg[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 mismatch", {7'd0, mismatch}, 8'd0);
      chk("R1 new_trace", {7'd0, new_trace}, 8'd0);
      chk("R1 out_of_align", {7'd0, out_of_align}, 8'd0);
      chk_read(4);

      // R3 cyclic sweep over lengths, R2 boundary at each length
      for (int l = 1; l <= 8; l++) begin
         set_cfg(0, l);
         for (int i = 0; i < l; i++) msg[i] = 8'((l * 16 + i * 3 + 1) & 8'h7F);
         send_msg(l, "R3 first");
         send_msg(l, "R3 repeat");
         msg[l-1] = msg[l-1] ^ 8'h40;
         send_msg(l, "R2 last byte changed");
         send_msg(l, "R3 clears");
         chk_read(l);
      end

      // R2 out-of-range length acts as 64
      set_cfg(0, 0);
      for (int i = 0; i < 64; i++) msg[i] = 8'(i * 5 + 7);
      for (int i = 0; i < 63; i++) send_byte(msg[i]);
      chk("R2 no finish at 63", {7'd0, new_trace}, 8'd0);
      send_byte(msg[63]);
      model_check(64, "R2 finish at 64");

      // R12 reserved code behaves as cyclic
      set_cfg(6, 3);
      msg[0] = 8'h11; msg[1] = 8'h22; msg[2] = 8'h33;
      send_msg(3, "R12 first");
      send_msg(3, "R12 repeat");

      // R4 programmed mode
      set_cfg(1, 4);
      for (int i = 0; i < 4; i++) write_exp(i, 8'(8'hA0 + i));
      write_exp(4, 8'hFF);
      for (int i = 0; i < 4; i++) msg[i] = 8'(8'hA0 + i);
      msg[4] = 8'h01;
      send_msg(4, "R4 match with byte beyond length differing");
      write_exp(2, 8'h00);
      send_msg(4, "R4 expected byte rewritten");
      chk_read(4);

      // R11 config change drops partial message
      set_cfg(0, 4);
      for (int i = 0; i < 4; i++) msg[i] = 8'(8'h51 + i);
      send_byte(msg[0]);
      send_byte(msg[1]);
      set_cfg(0, 3);
      msg[0] = 8'h61; msg[1] = 8'h62; msg[2] = 8'h63;
      send_byte(msg[0]);
      chk("R11 restart at position 0", {7'd0, new_trace}, 8'd0);
      send_byte(msg[1]);
      send_byte(msg[2]);
      model_check(3, "R11 finish after restart");

      // R8 persistence mode
      persist_n = 4'd3; cur_n = 3;
      set_cfg(4, 4);
      for (int i = 0; i < 4; i++) msg[i] = 8'(8'h70 + i);
      send_msg(4, "R8 repeat one");
      send_msg(4, "R8 repeat two");
      send_msg(4, "R8 repeat three accept");
      msg[1] = 8'h0F;
      send_msg(4, "R8 other message");
      msg[1] = 8'h71;
      send_msg(4, "R8 run broken");
      send_msg(4, "R8 run two");
      persist_n = 4'd0; cur_n = 0;
      msg[3] = 8'h55;
      send_msg(4, "R8 zero count accepts at once");
      chk_read(4);

      // R5 16-byte self-aligning mode
      set_cfg(3, 4);
      chk("R5 unaligned after entry", {7'd0, out_of_align}, 8'd1);
      send_byte(8'h12);
      chk("R5 no lock on clear bit 7", {7'd0, out_of_align}, 8'd1);
      chk("R7 no update while unaligned", {7'd0, mismatch}, {7'd0, e_mm});
      msg[0] = 8'hB1;
      for (int i = 1; i < 16; i++) msg[i] = 8'(8'h20 + i);
      send_byte(msg[0]);
      chk("R5 lock on start byte", {7'd0, out_of_align}, 8'd0);
      for (int i = 1; i < 16; i++) send_byte(msg[i]);
      model_check(16, "R7 16-byte first");
      send_msg(16, "R7 16-byte repeat");
      send_byte(8'h05);
      chk("R5 clear bit 7 at position 0", {7'd0, out_of_align}, 8'd1);
      send_byte(8'h81);
      for (int i = 1; i < 5; i++) send_byte(8'h44);
      msg[0] = 8'hC2;
      msg[5] = 8'h66;
      send_msg(16, "R5 restart mid-message");
      chk_read(16);

      // R6 64-byte self-aligning mode
      set_cfg(2, 4);
      chk("R6 unaligned after entry", {7'd0, out_of_align}, 8'd1);
      send_byte(8'h41); send_byte(8'h0D); send_byte(8'h42);
      chk("R6 lone CR", {7'd0, out_of_align}, 8'd1);
      send_byte(8'h0D); send_byte(8'h0A);
      chk("R6 lock on CR LF", {7'd0, out_of_align}, 8'd0);
      for (int i = 0; i < 62; i++) msg[i] = 8'(8'h30 + (i % 40));
      msg[62] = 8'h0D; msg[63] = 8'h0A;
      send_msg(64, "R6 64-byte first");
      send_msg(64, "R6 64-byte repeat");
      msg[63] = 8'h0B;
      for (int i = 0; i < 64; i++) send_byte(msg[i]);
      chk("R6 bad terminator unlocks", {7'd0, out_of_align}, 8'd1);
      chk("R6 bad message dropped", {7'd0, new_trace}, 8'd0);
      chk("R7 alarm kept on drop", {7'd0, mismatch}, {7'd0, e_mm});

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule